// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits on the write side of a memory protected by a single-error-correct, double-error-detect (SECDED) code. It sits between the ECC encoder and the storage array. Every request passes through it: a data word together with its check bits. On a write, the block can invert one bit or two adjacent bits of the codeword on their way to the array. A later read of that location then shows a corrected single-bit event or a non-correctable double-bit error. Software uses this to prove that the checker works and to exercise its error-logging routines. Read requests always pass through untouched.

A 16-bit control register selects what to inject. It holds a 7-bit codeword bit position and four mutually exclusive mode bits: single-bit continuous, single-bit one-shot, double-bit continuous and double-bit one-shot. A one-shot mode corrupts exactly one write and then clears its own mode bit. Injection happens only when a chip-level permission input is high. That input is the same one that allows single-bit correction events to be reported.

The codeword is numbered with the data bits first: codeword bit i is data bit i for i < DATA_W, and check bit i-DATA_W above that. The width of the check field is derived from DATA_W as the SECDED minimum.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset the control register reads 0x0000 and every request reaches the memory side unchanged.
- R2: A control write stores bits [11:8] (mode bits) and [6:0] (bit position); bits [15:12] and 7 always read as zero. The stored value is visible on the cycle after the write.
- R3: With exactly bit 8 or bit 9 set, a write inverts only codeword bit `pos`: data bit pos when pos < DATA_W, otherwise check bit pos-DATA_W.
- R4: With exactly bit 10 or bit 11 set, a write inverts codeword bits `pos` and `(pos+1) mod CW`, where CW = DATA_W + check width. Position CW-1 therefore pairs with bit 0.
- R5: Read requests (valid with write enable low), and cycles with valid low, pass to the memory side unchanged. Valid and write enable are always forwarded unchanged.
- R6: While the permission input is low, no write is altered and an armed one-shot bit stays set.
- R7: A continuous mode (bit 8 or bit 10) corrupts every write and leaves the register unchanged.
- R8: A one-shot mode (bit 9 or bit 11) corrupts the next write only and clears that mode bit on the following cycle. Reads do not consume it.
- R9: If more than one of bits [11:8] is set, no injection occurs.
- R10: A position of CW or greater disables injection.
- R11: A control write in the same cycle as a consuming write takes precedence over the one-shot clear. That write is still corrupted under the old setting.
- R12: Reading back a single-injected word through a SECDED decoder gives a corrected result equal to the original data. Reading back a double-injected word gives a non-correctable error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inj_allow | input | 1 | Chip-level permission (the same input that allows correction reporting) |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| cfg_value | output | 16 | Current control register contents |
| req_valid | input | 1 | Request valid from the encoder side |
| req_we | input | 1 | Request is a write |
| req_data | input | DATA_W | Data bits from the encoder |
| req_chk | input | CHK_W | Check bits from the encoder |
| mem_valid | output | 1 | Request valid to the array |
| mem_we | output | 1 | Write enable to the array |
| mem_data | output | DATA_W | Data bits to the array |
| mem_chk | output | CHK_W | Check bits to the array, possibly corrupted |

## Verification
The bench builds the block with DATA_W = 32, which gives 7 check bits and a 39-bit codeword. The 7-bit position field can then reach past the end of the codeword (39..127) as well as the last valid bit (38). Both the range cut-off and the wrap of the double-bit pair from bit 38 to bit 0 can be exercised. With this width the positions also fall on both sides of the data/check boundary. The bench pairs the block with an inline odd-weight-column SECDED code of the same width so that single and double injections can be read back as corrected and non-correctable events.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int CTL_W = 16;
    localparam int POS_W = 7;
    localparam logic [CTL_W-1:0] CTL_KEEP = 16'h0F7F;

    typedef struct packed {
        logic [3:0]       rsv_hi;
        logic             dbl_once;
        logic             dbl_cont;
        logic             sgl_once;
        logic             sgl_cont;
        logic             rsv_lo;
        logic [POS_W-1:0] pos;
    } ctl_t;

    function automatic int secded_chk_w(input int data_w);
        int r;
        r = 1;
        while ((1 << r) < (data_w + r + 1)) r++;
        return r + 1;
    endfunction

endpackage

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int CW = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inj_allow,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             wr_fire,
    output logic [CTL_W-1:0] cfg_value,
    output logic             active,
    output logic             dbl,
    output logic [POS_W-1:0] pos
);

    ctl_t ctl_d, ctl_q;
    logic [3:0] modes;
    logic one_mode, in_range, hit;

    always_comb begin
        modes    = {ctl_q.dbl_once, ctl_q.dbl_cont, ctl_q.sgl_once, ctl_q.sgl_cont};
        one_mode = ($countones(modes) == 1);
        in_range = (32'(ctl_q.pos) < CW);
        active   = inj_allow && one_mode && in_range;
        hit      = active && wr_fire;
        dbl      = ctl_q.dbl_cont || ctl_q.dbl_once;
        pos      = ctl_q.pos;
        ctl_d    = ctl_q;
        if (cfg_we) begin
            ctl_d = ctl_t'(cfg_wdata & CTL_KEEP);
        end else if (hit) begin
            ctl_d.sgl_once = 1'b0;
            ctl_d.dbl_once = 1'b0;
        end
        cfg_value = ctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    p_once_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg_we && (ctl_q.sgl_once || ctl_q.dbl_once))
        |=> (!ctl_q.sgl_once && !ctl_q.dbl_once && $stable(ctl_q.pos)));

    p_cont_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cfg_we && (ctl_q.sgl_cont || ctl_q.dbl_cont)) |=> $stable(ctl_q));

    p_cfg_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_value == ($past(cfg_wdata) & CTL_KEEP)));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_value & ~CTL_KEEP) == '0);

    p_multi_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(modes) > 1) |-> !active);

    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_allow && !cfg_we) |=> ($past(ctl_q.sgl_once) == ctl_q.sgl_once
                                     && $past(ctl_q.dbl_once) == ctl_q.dbl_once));

endmodule

// File: rtl/ecc_inj_mask.sv
module ecc_inj_mask
    import ecc_inj_pkg::*;
#(
    parameter int CW = 39
) (
    input  logic             en,
    input  logic             dbl,
    input  logic [POS_W-1:0] pos,
    output logic [CW-1:0]    mask
);

    for (genvar i = 0; i < CW; i++) begin : g_bit
        localparam int PREV = (i == 0) ? CW - 1 : i - 1;
        logic sel_self, sel_pair;
        always_comb begin
            sel_self = (pos == POS_W'(i));
            sel_pair = dbl && (pos == POS_W'(PREV));
            mask[i]  = en && (sel_self || sel_pair);
        end
    end

endmodule

// File: rtl/ecc_inj_apply.sv
module ecc_inj_apply #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7,
    localparam int CW    = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     mask,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CHK_W-1:0]  req_chk,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_data,
    output logic [CHK_W-1:0]  mem_chk
);

    logic [CW-1:0] cw_in, cw_out;
    logic          is_wr;

    always_comb begin
        is_wr  = req_valid && req_we;
        cw_in  = {req_chk, req_data};
        cw_out = is_wr ? (cw_in ^ mask) : cw_in;
        mem_valid = req_valid;
        mem_we    = req_we;
        mem_data  = cw_out[DATA_W-1:0];
        mem_chk   = cw_out[CW-1:DATA_W];
    end

    p_read_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_we) |-> (mem_data == req_data && mem_chk == req_chk));

    p_ctl_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid == req_valid) && (mem_we == req_we));

    p_flip_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_chk, mem_data} ^ {req_chk, req_data}) <= 2);

endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
    import ecc_inj_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CHK_W = ecc_inj_pkg::secded_chk_w(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_allow,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_value,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CHK_W-1:0]  req_chk,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_data,
    output logic [CHK_W-1:0]  mem_chk
);

    localparam int CW = DATA_W + CHK_W;

    logic             active, dbl, wr_fire;
    logic [POS_W-1:0] pos;
    logic [CW-1:0]    mask;

    assign wr_fire = req_valid && req_we;

    ecc_inj_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .inj_allow (inj_allow),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .wr_fire   (wr_fire),
        .cfg_value (cfg_value),
        .active    (active),
        .dbl       (dbl),
        .pos       (pos)
    );

    ecc_inj_mask #(.CW(CW)) u_mask (
        .en   (active),
        .dbl  (dbl),
        .pos  (pos),
        .mask (mask)
    );

    ecc_inj_apply #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask      (mask),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_data  (req_data),
        .req_chk   (req_chk),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_data  (mem_data),
        .mem_chk   (mem_chk)
    );

    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cfg_value[6:0]) >= CW) |-> ({mem_chk, mem_data} == {req_chk, req_data}));

    p_no_allow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_allow |-> ({mem_chk, mem_data} == {req_chk, req_data}));

endmodule

// File: tb/tb_ecc_wr_injector.sv
`timescale 1ns/1ps
module tb_ecc_wr_injector;

    localparam int DW = 32;
    localparam int CK = 7;
    localparam int CW = DW + CK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inj_allow = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_value;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic [CK-1:0] req_chk = '0;
    logic          mem_valid, mem_we;
    logic [DW-1:0] mem_data;
    logic [CK-1:0] mem_chk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    logic [CW-1:0] got_cw;

    always #5 clk = ~clk;

    ecc_wr_injector #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .inj_allow(inj_allow),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_value(cfg_value),
        .req_valid(req_valid), .req_we(req_we), .req_data(req_data), .req_chk(req_chk),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_data(mem_data), .mem_chk(mem_chk)
    );

    // ---------- inline SECDED model (odd-weight columns) ----------
    function automatic logic [CK-1:0] col(input int idx);
        int n = 0;
        for (int v = 0; v < (1 << CK); v++) begin
            if ($countones(v) == 3) begin
                if (n == idx) return CK'(v);
                n++;
            end
        end
        return '0;
    endfunction

    function automatic logic [CK-1:0] enc(input logic [DW-1:0] d);
        logic [CK-1:0] s = '0;
        for (int i = 0; i < DW; i++) if (d[i]) s ^= col(i);
        return s;
    endfunction

    // 0 clean, 1 corrected, 2 non-correctable
    function automatic int dec(input logic [DW-1:0] d, input logic [CK-1:0] c,
                               output logic [DW-1:0] fixed);
        logic [CK-1:0] syn;
        syn = c ^ enc(d);
        fixed = d;
        if (syn == '0) return 0;
        if ($countones(syn) % 2 == 0) return 2;
        if ($countones(syn) == 1) return 1;
        for (int i = 0; i < DW; i++) begin
            if (col(i) == syn) begin
                fixed[i] = ~fixed[i];
                return 1;
            end
        end
        return 2;
    endfunction

    // ---------- helpers ----------
    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [CW-1:0] flip(input logic [CW-1:0] cw, input int p, input bit two);
        logic [CW-1:0] r = cw;
        r[p] = ~r[p];
        if (two) r[(p + 1) % CW] = ~r[(p + 1) % CW];
        return r;
    endfunction

    task automatic cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one request cycle; returns codeword seen at the memory side
    task automatic txn(input bit we, input logic [DW-1:0] d, output logic [CW-1:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_data = d; req_chk = enc(d);
        #1;
        o = {mem_chk, mem_data};
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic check_ctl(input string tag, input logic [15:0] exp);
        #1;
        check(tag, 64'(cfg_value), 64'(exp));
    endtask

    // ---------- scenarios ----------
    task automatic t_reset();
        logic [DW-1:0] d = 32'hA5A5_0F0F;
        check_ctl("R1 control after reset", 16'h0000);
        inj_allow = 1'b1;
        txn(1'b1, d, got_cw);
        check("R1 write unchanged after reset", 64'(got_cw), 64'({enc(d), d}));
    endtask

    task automatic t_regs();
        cfg(16'hFFFF);
        check_ctl("R2 reserved bits read zero", 16'h0F7F);
        cfg(16'h0000);
        check_ctl("R2 cleared", 16'h0000);
    endtask

    task automatic t_single_cont();
        logic [DW-1:0] d = 32'h1234_5678;
        logic [DW-1:0] fx;
        int st;
        inj_allow = 1'b1;
        cfg(16'h0105);
        txn(1'b1, d, got_cw);
        check("R3 single flip data bit 5", 64'(got_cw), 64'(flip({enc(d), d}, 5, 1'b0)));
        st = dec(got_cw[DW-1:0], got_cw[CW-1:DW], fx);
        check("R12 single read back corrected", 64'(st), 64'd1);
        check("R12 corrected data", 64'(fx), 64'(d));
        txn(1'b1, ~d, got_cw);
        check("R7 continuous second write", 64'(got_cw), 64'(flip({enc(~d), ~d}, 5, 1'b0)));
        check_ctl("R7 register unchanged", 16'h0105);
        cfg(16'h0100 | 16'd35);
        txn(1'b1, d, got_cw);
        check("R3 single flip check bit 3", 64'(got_cw), 64'(flip({enc(d), d}, 35, 1'b0)));
        st = dec(got_cw[DW-1:0], got_cw[CW-1:DW], fx);
        check("R12 check-bit error corrected", 64'(st), 64'd1);
    endtask

    task automatic t_double();
        logic [DW-1:0] d = 32'hDEAD_BEEF;
        logic [DW-1:0] fx;
        int st;
        cfg(16'h0400 | 16'd10);
        txn(1'b1, d, got_cw);
        check("R4 double flip 10/11", 64'(got_cw), 64'(flip({enc(d), d}, 10, 1'b1)));
        st = dec(got_cw[DW-1:0], got_cw[CW-1:DW], fx);
        check("R12 double non-correctable", 64'(st), 64'd2);
        cfg(16'h0400 | 16'd38);
        txn(1'b1, d, got_cw);
        check("R4 double wraps 38/0", 64'(got_cw), 64'(flip({enc(d), d}, 38, 1'b1)));
        st = dec(got_cw[DW-1:0], got_cw[CW-1:DW], fx);
        check("R12 wrapped pair non-correctable", 64'(st), 64'd2);
    endtask

    task automatic t_read();
        logic [DW-1:0] d = 32'h0BAD_F00D;
        cfg(16'h0100 | 16'd0);
        txn(1'b0, d, got_cw);
        check("R5 read unchanged", 64'(got_cw), 64'({enc(d), d}));
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; #1;
        check("R5 valid forwarded", 64'(mem_valid), 64'd1);
        check("R5 we forwarded", 64'(mem_we), 64'd0);
        req_valid = 1'b0; req_we = 1'b1; req_data = d; req_chk = enc(d); #1;
        check("R5 idle with we high unchanged", 64'({mem_chk, mem_data}), 64'({enc(d), d}));
        req_we = 1'b0;
    endtask

    task automatic t_once();
        logic [DW-1:0] d = 32'h7777_0001;
        cfg(16'h0200 | 16'd3);
        txn(1'b0, d, got_cw);
        check_ctl("R8 read does not consume", 16'h0203);
        txn(1'b1, d, got_cw);
        check("R8 one-shot first write", 64'(got_cw), 64'(flip({enc(d), d}, 3, 1'b0)));
        check_ctl("R8 one-shot bit cleared", 16'h0003);
        txn(1'b1, d, got_cw);
        check("R8 second write clean", 64'(got_cw), 64'({enc(d), d}));
        cfg(16'h0800 | 16'd7);
        txn(1'b1, d, got_cw);
        check("R8 double one-shot", 64'(got_cw), 64'(flip({enc(d), d}, 7, 1'b1)));
        check_ctl("R8 double one-shot cleared", 16'h0007);
    endtask

    task automatic t_gate();
        logic [DW-1:0] d = 32'h0000_FFFF;
        inj_allow = 1'b0;
        cfg(16'h0200 | 16'd4);
        txn(1'b1, d, got_cw);
        check("R6 no injection while not allowed", 64'(got_cw), 64'({enc(d), d}));
        check_ctl("R6 one-shot stays armed", 16'h0204);
        inj_allow = 1'b1;
        txn(1'b1, d, got_cw);
        check("R6 injection once allowed", 64'(got_cw), 64'(flip({enc(d), d}, 4, 1'b0)));
    endtask

    task automatic t_multi();
        logic [DW-1:0] d = 32'h5555_AAAA;
        cfg(16'h0300 | 16'd2);
        txn(1'b1, d, got_cw);
        check("R9 two modes no injection", 64'(got_cw), 64'({enc(d), d}));
        check_ctl("R9 register untouched", 16'h0302);
    endtask

    task automatic t_range();
        logic [DW-1:0] d = 32'hCAFE_0000;
        cfg(16'h0100 | 16'd39);
        txn(1'b1, d, got_cw);
        check("R10 position 39 disabled", 64'(got_cw), 64'({enc(d), d}));
        cfg(16'h0100 | 16'd127);
        txn(1'b1, d, got_cw);
        check("R10 position 127 disabled", 64'(got_cw), 64'({enc(d), d}));
        cfg(16'h0100 | 16'd38);
        txn(1'b1, d, got_cw);
        check("R10 position 38 active", 64'(got_cw), 64'(flip({enc(d), d}, 38, 1'b0)));
    endtask

    task automatic t_collide();
        logic [DW-1:0] d = 32'h0F0F_F0F0;
        cfg(16'h0200 | 16'd1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0800 | 16'd9;
        req_valid = 1'b1; req_we = 1'b1; req_data = d; req_chk = enc(d);
        #1;
        check("R11 write uses old setting", 64'({mem_chk, mem_data}),
              64'(flip({enc(d), d}, 1, 1'b0)));
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        check_ctl("R11 register write wins", 16'h0809);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_single_cont();
        t_double();
        t_read();
        t_once();
        t_gate();
        t_multi();
        t_range();
        t_collide();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule